// File: doc/BRIEF.md
# Dual-Match Down-Counting Timer Channel

One channel of a periodic timer. A 32-bit counter is loaded from a reload register and steps down by one on every selected tick. When it reaches zero it reloads on the next tick, so it repeats with a period of reload + 1 ticks. Two match thresholds can each raise an interrupt event as the count passes them, and reaching zero can raise an overflow event. Each event flips a level-type interrupt line and gives a one-cycle strobe that a shared status register can latch.

Software drives the channel through a small indexed register port and three control bits: enable, tick source and overflow-interrupt enable. The two thresholds are independent, and no order between them is assumed. Pulse-output generation and address decoding belong to the surrounding logic.

Top module: `dmatch_timer_chan`

## Requirements
- R1: While enabled with a non-zero reload, each tick lowers the count by one. A tick at count zero loads the reload value, so the count repeats every reload + 1 ticks.
- R2: A match threshold whose stored value is equal to or above the reload value acts as a threshold of zero.
- R3: An event fires when a decrement lands on a non-zero effective threshold. The two thresholds may be held in either order. When both hold the same value, only one event fires.
- R4: When a decrement lands on zero, an event fires if the overflow-interrupt enable is set or if either effective threshold is zero. Otherwise no event fires.
- R5: Each event inverts `irq_level` and raises `evt_strobe` for exactly one cycle. Both are seen in the same cycle in which the count first shows the value that caused the event.
- R6: `reg_rdata` is combinational from `reg_idx`. Index 0 gives the live count while enabled and the reload value while disabled. Index 1 gives the reload value, index 2 the first threshold and index 3 the second threshold.
- R7: A write to index 0 while enabled replaces the count on the next cycle and takes priority over a tick.
- R8: While the reload value is zero, the count holds and no event fires. If a non-zero reload is written while enabled and the old reload was zero, the count takes the written value.
- R9: With `clk_sel` at 1, the count moves only on cycles where `tick_1m` is high. With `clk_sel` at 0, it moves on every cycle.
- R10: A rising `en` loads the count from reload, and no tick is applied on that cycle. While `en` is low, the count is frozen and no event fires.
- R11: After reset, the count, the reload value, both thresholds, `irq_level` and `evt_strobe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1m | input | 1 | External 1 MHz tick enable, one cycle wide |
| en | input | 1 | Channel enable |
| clk_sel | input | 1 | 1 selects the external tick, 0 selects every bus cycle |
| ovf_ie | input | 1 | Overflow-interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index: 0 count, 1 reload, 2 first threshold, 3 second threshold |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` |
| irq_level | output | 1 | Interrupt line, toggled on each event |
| evt_strobe | output | 1 | One-cycle event pulse for the shared status register |

## Verification
The thresholds are tried in ascending order, in descending order, with one at or above reload, with a raw zero, and with both equal. These cases show whether the event order depends on register order, whether the clamp to zero works, and whether a shared value fires twice. Runs with overflow enable on and off show when the zero event is gated. A count overwrite in mid-period and a start from a zero reload show the two ways the count is loaded outside the normal wrap. Hand-pulsed external ticks show that the counter holds between ticks.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int unsigned DMT_CNT_W = 32;

  typedef enum logic [1:0] {
    IDX_COUNT   = 2'd0,
    IDX_RELOAD  = 2'd1,
    IDX_MATCH_A = 2'd2,
    IDX_MATCH_B = 2'd3
  } dmt_idx_e;
endpackage

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel #(
  parameter bit EXT_TICK_EN = 1'b1
) (
  input  logic tick_1m,
  input  logic clk_sel,
  output logic tick
);
  generate
    if (EXT_TICK_EN) begin : g_ext
      assign tick = clk_sel ? tick_1m : 1'b1;
    end else begin : g_bus
      logic unused_ok;
      assign unused_ok = tick_1m ^ clk_sel;
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = DMT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_idx,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] match_a_q,
  output logic [CNT_W-1:0] match_b_q,
  output logic             wr_count,
  output logic             wr_reload
);
  logic wr_ma, wr_mb;

  assign wr_count  = reg_wr && (reg_idx == IDX_COUNT);
  assign wr_reload = reg_wr && (reg_idx == IDX_RELOAD);
  assign wr_ma     = reg_wr && (reg_idx == IDX_MATCH_A);
  assign wr_mb     = reg_wr && (reg_idx == IDX_MATCH_B);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= '0;
      match_a_q <= '0;
      match_b_q <= '0;
    end else begin
      if (wr_reload) reload_q  <= reg_wdata;
      if (wr_ma)     match_a_q <= reg_wdata;
      if (wr_mb)     match_b_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = DMT_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             ovf_ie,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] match_a,
  input  logic [CNT_W-1:0] match_b,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             evt_now
);
  // threshold clamp: values at or above reload behave as zero
  function automatic logic [CNT_W-1:0] eff_thr(input logic [CNT_W-1:0] m,
                                               input logic [CNT_W-1:0] rl);
    return (m < rl) ? m : '0;
  endfunction

  function automatic logic lands_on_event(input logic [CNT_W-1:0] nxt,
                                          input logic [CNT_W-1:0] ea,
                                          input logic [CNT_W-1:0] eb,
                                          input logic             ovf);
    logic zero_armed;
    zero_armed = ovf || (ea == '0) || (eb == '0);
    if (nxt == '0) return zero_armed;
    return (nxt == ea) || (nxt == eb);
  endfunction

  logic             en_q;
  logic [CNT_W-1:0] cnt_d;
  logic             dec;
  logic             start_load;
  logic [CNT_W-1:0] ea, eb;

  assign ea         = eff_thr(match_a, reload);
  assign eb         = eff_thr(match_b, reload);
  assign start_load = wr_reload && (reload == '0) && (wdata != '0);

  always_comb begin
    cnt_d = cnt_q;
    dec   = 1'b0;
    if (en && !en_q) begin
      cnt_d = reload;
    end else if (en) begin
      if (wr_count) begin
        cnt_d = wdata;
      end else if (start_load) begin
        cnt_d = wdata;
      end else if (tick && (reload != '0)) begin
        if (cnt_q == '0) begin
          cnt_d = reload;
        end else begin
          cnt_d = cnt_q - 1'b1;
          dec   = 1'b1;
        end
      end
    end
  end

  assign evt_now = dec && lands_on_event(cnt_d, ea, eb, ovf_ie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en;
    end
  end

  AST_FREEZE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q)); // R10
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q) |=> (cnt_q == $past(reload))); // R10
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && tick && !wr_count && !wr_reload && cnt_q == '0 && reload != '0)
      |=> (cnt_q == $past(reload))); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && tick && !wr_count && !start_load && cnt_q != '0 && reload != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R1
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && en_q && !tick && !wr_count && !wr_reload) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_now,
  output logic irq_q,
  output logic strobe_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      irq_q    <= irq_q ^ evt_now;
      strobe_q <= evt_now;
    end
  end

  AST_IRQ_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q == (irq_q != $past(irq_q))); // R5
endmodule

// File: rtl/dmatch_timer_chan.sv
module dmatch_timer_chan
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W       = DMT_CNT_W,
  parameter bit          EXT_TICK_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1m,
  input  logic             en,
  input  logic             clk_sel,
  input  logic             ovf_ie,
  input  logic             reg_wr,
  input  logic [1:0]       reg_idx,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq_level,
  output logic             evt_strobe
);
  logic             tick;
  logic [CNT_W-1:0] reload_q, match_a_q, match_b_q, cnt_q;
  logic             wr_count, wr_reload, evt_now;

  dmt_tick_sel #(.EXT_TICK_EN(EXT_TICK_EN)) u_tick (
    .tick_1m(tick_1m), .clk_sel(clk_sel), .tick(tick)
  );

  dmt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reload_q(reload_q), .match_a_q(match_a_q),
    .match_b_q(match_b_q), .wr_count(wr_count), .wr_reload(wr_reload)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ovf_ie(ovf_ie),
    .reload(reload_q), .match_a(match_a_q), .match_b(match_b_q),
    .wr_count(wr_count), .wr_reload(wr_reload), .wdata(reg_wdata),
    .cnt_q(cnt_q), .evt_now(evt_now)
  );

  dmt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt_now(evt_now),
    .irq_q(irq_level), .strobe_q(evt_strobe)
  );

  always_comb begin
    case (reg_idx)
      IDX_COUNT:   reg_rdata = en ? cnt_q : reload_q;
      IDX_RELOAD:  reg_rdata = reload_q;
      IDX_MATCH_A: reg_rdata = match_a_q;
      default:     reg_rdata = match_b_q;
    endcase
  end

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !evt_strobe); // R10
  AST_IDLE_ZERO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0) |=> !evt_strobe); // R8
endmodule

// File: tb/tb_dmatch_timer_chan.sv
`timescale 1ns/1ps
module tb_dmatch_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1m = 1'b0;
  logic        en = 1'b0;
  logic        clk_sel = 1'b0;
  logic        ovf_ie = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_level, evt_strobe;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] cnt; logic irq; } exp_t;
  exp_t q[$];
  logic irq_exp = 1'b0;

  always #10 clk = ~clk;

  dmatch_timer_chan dut (
    .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .en(en), .clk_sel(clk_sel),
    .ovf_ie(ovf_ie), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_level(irq_level), .evt_strobe(evt_strobe)
  );

  // driver side: expected events in order (R3, R5)
  task automatic push(input logic [31:0] c);
    exp_t e;
    irq_exp = ~irq_exp;
    e.cnt = c;
    e.irq = irq_exp;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_idx = 2'd0;
  endtask

  task automatic check(input string req, input logic [1:0] idx, input logic [31:0] exp);
    reg_idx = idx;
    #1;
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s idx%0d actual=%0d expected=%0d", req, idx, reg_rdata, exp);
    end
    reg_idx = 2'd0;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // monitor: pops one expected event per strobe
  always @(posedge clk) begin
    #5;
    if (rst_n && evt_strobe) begin
      compared++;
      if (q.size() == 0) begin
        mismatched++;
        $display("FAIL R3/R4 unexpected event actual cnt=%0d expected=no event", reg_rdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if ((reg_idx == 2'd0 && reg_rdata !== e.cnt) || irq_level !== e.irq) begin
          mismatched++;
          $display("FAIL R5 event actual cnt=%0d irq=%0b expected cnt=%0d irq=%0b",
                   reg_rdata, irq_level, e.cnt, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R11 reset state
    check("R11", 2'd0, 32'd0);
    check("R11", 2'd1, 32'd0);
    check("R11", 2'd2, 32'd0);
    check("R11", 2'd3, 32'd0);
    check_bit("R11 irq", irq_level, 1'b0);
    check_bit("R11 strobe", evt_strobe, 1'b0);

    // R3 ascending thresholds, R4 zero event with overflow enable
    ovf_ie = 1'b1;
    wr(2'd1, 32'd10); wr(2'd2, 32'd3); wr(2'd3, 32'd7);
    push(32'd7); push(32'd3); push(32'd0);
    en = 1'b1;
    step(1);
    check("R10 restart", 2'd0, 32'd10);
    step(12);
    check("R1 wrap", 2'd0, 32'd9);
    en = 1'b0;
    step(1);
    check("R6 disabled", 2'd0, 32'd10);
    check("R6 match1", 2'd2, 32'd3);
    check("R6 match2", 2'd3, 32'd7);

    // R3 descending thresholds, R4 no zero event
    ovf_ie = 1'b0;
    wr(2'd2, 32'd8); wr(2'd3, 32'd2);
    push(32'd8); push(32'd2);
    en = 1'b1;
    step(13);
    en = 1'b0;
    step(1);
    check("R6 disabled", 2'd0, 32'd10);

    // R2 threshold equal to reload acts as zero
    wr(2'd2, 32'd10); wr(2'd3, 32'd5);
    push(32'd5); push(32'd0);
    en = 1'b1;
    step(13);
    en = 1'b0;
    step(1);

    // R4 raw zero threshold arms zero event
    wr(2'd1, 32'd6); wr(2'd2, 32'd0); wr(2'd3, 32'd4);
    push(32'd4); push(32'd0);
    en = 1'b1;
    step(9);
    check("R1 wrap", 2'd0, 32'd5);
    en = 1'b0;
    step(1);

    // R7 overwrite count while enabled
    ovf_ie = 1'b1;
    wr(2'd1, 32'd20); wr(2'd2, 32'd15); wr(2'd3, 32'd5);
    push(32'd5); push(32'd0);
    en = 1'b1;
    step(2);
    wr(2'd0, 32'd6);
    check("R7", 2'd0, 32'd6);
    step(8);
    check("R7 wrap", 2'd0, 32'd19);
    en = 1'b0;
    step(1);

    // R8 zero reload holds, then start by reload write
    ovf_ie = 1'b0;
    wr(2'd1, 32'd0); wr(2'd2, 32'd2); wr(2'd3, 32'd2);
    en = 1'b1;
    step(5);
    check("R8 hold", 2'd0, 32'd0);
    push(32'd2);
    wr(2'd1, 32'd5);
    check("R8 start", 2'd0, 32'd5);
    step(1);
    check("R8 run", 2'd0, 32'd4);
    step(5);
    check("R1 wrap", 2'd0, 32'd5);
    en = 1'b0;
    step(1);

    // R9 external tick source
    clk_sel = 1'b1; ovf_ie = 1'b1;
    wr(2'd1, 32'd3); wr(2'd2, 32'd1); wr(2'd3, 32'd2);
    push(32'd2); push(32'd1); push(32'd0);
    en = 1'b1;
    step(1);
    check("R10 restart", 2'd0, 32'd3);
    step(10);
    check("R9 no tick", 2'd0, 32'd3);
    for (int k = 0; k < 3; k++) begin
      tick_1m = 1'b1; step(1); tick_1m = 1'b0;
      step(4);
    end
    check("R9 ticks", 2'd0, 32'd0);
    tick_1m = 1'b1; step(1); tick_1m = 1'b0;
    check("R9 wrap", 2'd0, 32'd3);
    en = 1'b0; clk_sel = 1'b0;
    step(5);

    compared++;
    if (q.size() != 0) begin
      mismatched++;
      $display("FAIL R3/R4 missing events actual=%0d pending expected=0", q.size());
    end
    check_bit("R5 final irq", irq_level, irq_exp);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule